// File: doc/BRIEF.md
# Packet Stream Protocol Compliance Monitor

This block sits beside one streaming port of another module and watches, cycle by cycle, whether traffic on that port keeps to a legal packet timeline. It observes three signals. The caller's input strobe and its final-element marker are on one side. The checked module's output strobe is on the other. A small deterministic state machine follows the allowed pattern and tests two separate obligations. The caller must feed elements in the permitted shape. The checked module must drive its output only in the cycles the pattern allows.

Two timelines are supported, selected by a mode input. In terminated mode a packet is any run of non-final elements closed by a final element, and the module must answer exactly in the cycle that consumes the final element. In burst mode, which suits an unpacker-style port, one accepted input opens a window of `BURST_LEN` output cycles. No new input may arrive during that window, and the output must be present in every cycle of it. Each violation sets a sticky flag for its class and records the first cause. The flags stay set until a synchronous active-low reset or a clear pulse.

Top module: `pkt_timeline_mon`

## Requirements
- R1: While `rst_n` is low at a clock edge, the monitor returns to `phase` = 0 (inactive) with `err_flags` = 0 and `err_cause` = 0.
- R2: In terminated mode (`mode` = 0), `phase` follows these codes: 0 inactive, 1 accumulating, 2 completing. From inactive or completing, a strobe without the final marker leads to 1, a strobe with it leads to 2, and no strobe leads to 0. From accumulating, a strobe with the final marker leads to 2 and one without it stays in 1. A new packet may therefore start in the cycle right after a final element.
- R3: In terminated mode, a cycle in state 1 with `in_valid` low is a caller violation: `err_flags` bit 0 is set, and if no cause is recorded yet, `err_cause` becomes 1. The state stays 1.
- R4: In terminated mode, `out_valid` high in any cycle that does not consume a final element is an unexpected-output violation: bit 2 is set and the cause code is 3.
- R5: In terminated mode, a cycle that consumes a final element with `out_valid` low is a missing-output violation: bit 1 is set and the cause code is 2.
- R6: In burst mode (`mode` = 1), `in_valid` while inactive accepts a packet. `phase` reads 3 for the `BURST_LEN`-1 cycles after the accept and then 0, so a new packet can be accepted in the very next cycle.
- R7: In burst mode, `in_valid` high during the `BURST_LEN`-1 cycles after an accept is a caller violation (bit 0, cause 1). It does not restart or extend the window.
- R8: In burst mode, `out_valid` must be high in the accept cycle and in each of the following `BURST_LEN`-1 cycles. A low output there is missing-output (bit 1, cause 2). A high output outside such a window is unexpected (bit 2, cause 3).
- R9: Flags are sticky. They clear only on reset or on a `clr` cycle, and `clr` leaves `phase` untouched. A violation detected in the same cycle as `clr` is still recorded.
- R10: `err_cause` keeps the first recorded cause until cleared. When several violations arise in one cycle, the cause code gives priority to caller, then missing, then unexpected. All of their flag bits are set.
- R11: A `mode` change while `phase` is 1 or 3 is a caller violation, and the latched mode stays in force until the monitor is inactive. `in_last` has no effect in burst mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Clears the sticky flags and the cause code |
| mode | input | 1 | 0 terminated timeline, 1 fixed-burst timeline |
| in_valid | input | 1 | Caller's input strobe |
| in_last | input | 1 | Caller's final-element marker |
| out_valid | input | 1 | Checked module's output strobe |
| phase | output | 2 | 0 inactive, 1 accumulating, 2 completing, 3 burst window |
| err_flags | output | 3 | Sticky: bit 0 caller, bit 1 missing output, bit 2 unexpected output |
| err_cause | output | 2 | First cause: 0 none, 1 caller, 2 missing, 3 unexpected |

## Verification
The bench builds the monitor with `BURST_LEN` = 3. This is long enough to have a quiet cycle in the middle of a window and short enough that a full window, a back-to-back accept and an intrusion all fit in a few cycles. Window expectations are derived from the parameter, so the edge where phase 3 falls back to 0 is tested at its exact cycle. The same parameter lets a caller violation in the middle of a window be told apart from one at its end. The terminated-mode scenarios cover single-element packets that repeat the completing state, a clear arriving together with a fresh violation, and a mode switch that is refused during an open packet.

// File: rtl/ptm_pkg.sv
// Shared encodings for the packet timeline monitor.
package ptm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ACCUM = 2'd1,
        PH_FINAL = 2'd2,
        PH_BURST = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_CALLER  = 2'd1,
        CAUSE_MISSING = 2'd2,
        CAUSE_EXTRA   = 2'd3
    } cause_e;

    // bit 0 caller, bit 1 missing output, bit 2 unexpected output
    typedef struct packed {
        logic extra;
        logic missing;
        logic caller;
    } viol_t;

endpackage

// File: rtl/ptm_seq_fsm.sv
// Terminated-timeline tracker.
// Follows inactive / accumulating / completing and reports caller and
// output violations for the current cycle. Assumes en is low only while
// the state is not accumulating (the top guarantees this).
module ptm_seq_fsm
    import ptm_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  logic   in_valid,
    input  logic   in_last,
    input  logic   out_valid,
    output phase_e phase,
    output viol_t  viol
);

    phase_e phase_q, phase_d;

    // Next state and violations of the current cycle.
    always_comb begin
        phase_d = PH_IDLE;
        viol    = '0;
        if (en) begin
            case (phase_q)
                PH_ACCUM: begin
                    if (!in_valid) begin
                        phase_d     = PH_ACCUM;
                        viol.caller = 1'b1;
                    end else begin
                        phase_d = in_last ? PH_FINAL : PH_ACCUM;
                    end
                end
                default: begin
                    if (in_valid) phase_d = in_last ? PH_FINAL : PH_ACCUM;
                    else          phase_d = PH_IDLE;
                end
            endcase
            viol.missing = in_valid & in_last & ~out_valid;
            viol.extra   = out_valid & ~(in_valid & in_last);
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    assign phase = phase_q;

endmodule

// File: rtl/ptm_burst_track.sv
// Fixed-burst tracker.
// One accepted input opens a window of BURST_LEN output cycles. Input is
// forbidden during the last BURST_LEN-1 of them. Assumes 2 <= BURST_LEN <= 16.
module ptm_burst_track
    import ptm_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  logic  in_valid,
    input  logic  out_valid,
    output logic  busy,
    output viol_t viol
);

    localparam int              CNT_W  = $clog2(BURST_LEN);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(BURST_LEN - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             accept, need_out;

    // Accept decision, output obligation and violations.
    always_comb begin
        busy         = (cnt_q != '0);
        accept       = en & in_valid & ~busy;
        need_out     = accept | busy;
        viol.caller  = in_valid & busy;
        viol.missing = need_out & ~out_valid;
        viol.extra   = en & ~need_out & out_valid;
        if (accept)    cnt_d = RELOAD;
        else if (busy) cnt_d = cnt_q - CNT_W'(1);
        else           cnt_d = '0;
    end

    // Remaining-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ptm_err_latch.sv
// Sticky violation record.
// Keeps one flag per class and the first cause. A violation in a clear
// cycle is still recorded.
module ptm_err_latch
    import ptm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  viol_t      viol,
    output logic [2:0] flags,
    output cause_e     cause
);

    logic [2:0] flags_q, base_flags;
    cause_e     cause_q, base_cause, new_cause;

    // Priority encode the violations of this cycle.
    always_comb begin
        if (viol.caller)       new_cause = CAUSE_CALLER;
        else if (viol.missing) new_cause = CAUSE_MISSING;
        else if (viol.extra)   new_cause = CAUSE_EXTRA;
        else                   new_cause = CAUSE_NONE;
        base_flags = clr ? 3'b000 : flags_q;
        base_cause = clr ? CAUSE_NONE : cause_q;
    end

    // Flag and cause registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            flags_q <= base_flags | viol;
            cause_q <= (base_cause != CAUSE_NONE) ? base_cause : new_cause;
        end
    end

    assign flags = flags_q;
    assign cause = cause_q;

endmodule

// File: rtl/pkt_timeline_mon.sv
// Packet timeline compliance monitor.
// Selects the terminated or fixed-burst tracker by mode, latches the mode
// while a packet is open, and merges the violations into a sticky record.
// Assumes the watched port's signals are synchronous to clk.
module pkt_timeline_mon
    import ptm_pkg::*;
#(
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       mode,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       out_valid,
    output logic [1:0] phase,
    output logic [2:0] err_flags,
    output logic [1:0] err_cause
);

    phase_e seq_phase;
    viol_t  seq_viol, burst_viol, all_viol;
    logic   burst_busy, busy, mode_q, eff_mode, mode_err;
    cause_e cause;

    // Mode in force: latched while a packet is open.
    always_comb begin
        busy     = (seq_phase == PH_ACCUM) | burst_busy;
        eff_mode = busy ? mode_q : mode;
        mode_err = busy & (mode != mode_q);
    end

    // Mode latch.
    always_ff @(posedge clk) begin
        if (!rst_n)     mode_q <= 1'b0;
        else if (!busy) mode_q <= mode;
    end

    ptm_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (~eff_mode),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .out_valid (out_valid),
        .phase     (seq_phase),
        .viol      (seq_viol)
    );

    ptm_burst_track #(.BURST_LEN(BURST_LEN)) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (eff_mode),
        .in_valid  (in_valid),
        .out_valid (out_valid),
        .busy      (burst_busy),
        .viol      (burst_viol)
    );

    // Merge violations of both trackers and the mode rule.
    always_comb begin
        all_viol        = seq_viol | burst_viol;
        all_viol.caller = all_viol.caller | mode_err;
    end

    ptm_err_latch u_err (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .viol  (all_viol),
        .flags (err_flags),
        .cause (cause)
    );

    assign err_cause = cause;
    assign phase     = burst_busy ? PH_BURST : seq_phase;

endmodule

// File: rtl/ptm_checker.sv
// Property checker for pkt_timeline_mon, attached by bind.
module ptm_checker #(
    parameter int BURST_LEN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       clr,
    input logic       mode,
    input logic       in_valid,
    input logic       in_last,
    input logic       out_valid,
    input logic [1:0] phase,
    input logic [2:0] err_flags,
    input logic [1:0] err_cause
);

    initial begin
        a_r6_len_range: assert (BURST_LEN >= 2 && BURST_LEN <= 16);
    end

    // R9: flags never drop without clr
    a_r9_flags_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

    // R10: first cause held
    a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause != 2'd0 && !clr) |=> $stable(err_cause));

    // R10: cause recorded exactly when some flag is set
    a_r10_cause_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (err_cause != 2'd0) == (err_flags != 3'd0));

    // R2: final element closes an accumulating packet
    a_r2_last_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && in_valid && in_last) |=> (phase == 2'd2));

    // R3: gap inside a packet is a caller violation
    a_r3_gap_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && !in_valid) |=> (err_flags[0] && phase == 2'd1));

    // R5: final element without output is flagged
    a_r5_missing_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 2'd1 && in_valid && in_last && !out_valid) |=> err_flags[1]);

    // R4 / R8: output while inactive and idle input is unexpected
    a_r4_extra_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd0 || phase == 2'd2) && !in_valid && out_valid) |=> err_flags[2]);

    // R6: burst accept opens a window
    a_r6_burst_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 2'd0 || phase == 2'd2) && mode && in_valid) |=> (phase == 2'd3));

endmodule

bind pkt_timeline_mon ptm_checker #(.BURST_LEN(BURST_LEN)) u_chk (.*);

// File: tb/pkt_timeline_mon_bench.sv
module pkt_timeline_mon_bench;

    localparam int N = 3;

    logic       clk = 1'b0;
    logic       rst_n, clr, mode, in_valid, in_last, out_valid;
    logic [1:0] phase;
    logic [2:0] err_flags;
    logic [1:0] err_cause;
    int         total = 0;
    int         bad = 0;

    always #2.5 clk = ~clk;

    pkt_timeline_mon #(.BURST_LEN(N)) u_pkt_timeline_mon (
        .clk(clk), .rst_n(rst_n), .clr(clr), .mode(mode),
        .in_valid(in_valid), .in_last(in_last), .out_valid(out_valid),
        .phase(phase), .err_flags(err_flags), .err_cause(err_cause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic l, input logic o);
        in_valid = v; in_last = l; out_valid = o;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0; clr = 1'b0; mode = m;
        in_valid = 1'b0; in_last = 1'b0; out_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset(1'b0);
        chk("R1 phase", phase, 0);
        chk("R1 flags", err_flags, 0);
        chk("R1 cause", err_cause, 0);
    endtask

    task automatic t_terminated();
        do_reset(1'b0);
        step(1, 0, 0); chk("R2 first", phase, 1);
        step(1, 0, 0); chk("R2 stay", phase, 1);
        step(1, 1, 1); chk("R2 final", phase, 2);
        step(1, 1, 1); chk("R2 single reenter", phase, 2);
        step(1, 0, 0); chk("R2 back to back", phase, 1);
        step(1, 1, 1); chk("R2 final again", phase, 2);
        step(0, 0, 0); chk("R2 inactive", phase, 0);
        chk("R2 clean", err_flags, 0);
    endtask

    task automatic t_gap();
        do_reset(1'b0);
        step(1, 0, 0);
        step(0, 0, 0);
        chk("R3 phase held", phase, 1);
        chk("R3 flags", err_flags, 3'b001);
        chk("R3 cause", err_cause, 1);
        step(1, 1, 1); chk("R3 closes", phase, 2);
    endtask

    task automatic t_extra_missing();
        do_reset(1'b0);
        step(0, 0, 1);
        chk("R4 idle output", err_flags, 3'b100);
        chk("R4 cause", err_cause, 3);
        step(1, 0, 1);
        chk("R4 nonfinal output", err_flags, 3'b100);
        step(1, 1, 0);
        chk("R10 second kind adds flag", err_flags, 3'b110);
        chk("R10 first cause kept", err_cause, 3);
        repeat (3) step(0, 0, 0);
        chk("R9 sticky", err_flags, 3'b110);
    endtask

    task automatic t_missing();
        do_reset(1'b0);
        step(1, 1, 0);
        chk("R5 flags", err_flags, 3'b010);
        chk("R5 cause", err_cause, 2);
        chk("R5 phase", phase, 2);
    endtask

    task automatic t_clear();
        do_reset(1'b0);
        step(1, 0, 1);
        chk("R9 pre flags", err_flags, 3'b100);
        clr = 1'b1; step(1, 0, 0); clr = 1'b0;
        chk("R9 cleared", err_flags, 0);
        chk("R9 cause cleared", err_cause, 0);
        chk("R9 phase kept", phase, 1);
        clr = 1'b1; step(0, 0, 0); clr = 1'b0;
        chk("R9 error wins clear", err_flags, 3'b001);
        chk("R9 cause in clear cycle", err_cause, 1);
    endtask

    task automatic t_priority();
        do_reset(1'b0);
        step(1, 0, 0);
        step(0, 0, 1);
        chk("R10 both flags", err_flags, 3'b101);
        chk("R10 caller first", err_cause, 1);
    endtask

    task automatic t_burst();
        do_reset(1'b1);
        step(1, 1, 1); chk("R11 last ignored", phase, 3);
        for (int k = 1; k < N; k++) begin
            step(0, 0, 1);
            chk("R6 window", phase, (k < N - 1) ? 3 : 0);
        end
        step(1, 0, 1); chk("R6 back to back", phase, 3);
        for (int k = 1; k < N; k++) step(0, 0, 1);
        chk("R6 end", phase, 0);
        chk("R6 clean", err_flags, 0);
    endtask

    task automatic t_burst_intrude();
        do_reset(1'b1);
        step(1, 0, 1);
        step(1, 0, 1);
        chk("R7 flags", err_flags, 3'b001);
        chk("R7 cause", err_cause, 1);
        chk("R7 still open", phase, (N > 2) ? 3 : 0);
        for (int k = 2; k < N; k++) step(0, 0, 1);
        chk("R7 no restart", phase, 0);
    endtask

    task automatic t_burst_outputs();
        do_reset(1'b1);
        step(1, 0, 1);
        step(0, 0, 0);
        chk("R8 missing", err_flags, 3'b010);
        chk("R8 cause", err_cause, 2);
        for (int k = 2; k < N; k++) step(0, 0, 1);
        step(0, 0, 1);
        chk("R8 outside window", err_flags, 3'b110);
    endtask

    task automatic t_mode_switch();
        do_reset(1'b0);
        step(1, 0, 0);
        mode = 1'b1;
        step(1, 0, 0);
        chk("R11 switch flagged", err_flags, 3'b001);
        chk("R11 latched mode", phase, 1);
        step(1, 1, 1);
        chk("R11 still terminated", phase, 2);
        step(1, 0, 1);
        chk("R11 new mode once inactive", phase, 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_terminated();
        t_gap();
        t_extra_missing();
        t_missing();
        t_clear();
        t_priority();
        t_burst();
        t_burst_intrude();
        t_burst_outputs();
        t_mode_switch();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule